// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block paces the refresh of a dynamic memory array. Cells lose their charge within a few milliseconds, so every row must be opened once per retention window. Opening a row is a dummy read, and it restores all the cells on that row together. The scheduler divides the window (given in clock cycles) by the number of rows. This spreads the refreshes evenly and avoids bursting them. On each resulting interval it owes the controller one more row refresh. It offers the owed refreshes on a valid/ready request channel, together with the row to open.

A dedicated row counter walks the rows in ascending order and returns to zero after the last one. It advances only when the controller grants a request. The request channel follows valid/ready rules. Once `req_valid` is high it stays high, with `req_row` unchanged, until the controller takes it with `req_ready`. The controller may hold `req_ready` low for as long as it needs, but refreshes owed beyond eight are dropped. Once two or more refreshes are owed, an urgency flag tells the controller to give refresh priority over user traffic. Each granted refresh holds a write-block output for a fixed number of cycles, while the row is open. Arbitration against user accesses and the memory pins are outside this block.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted and right after it, `req_valid`, `urgent`, `wrap_pulse` and `wr_block` are 0 and `req_row` is 0.
- R2: The interval is floor(`cfg_period` / `cfg_rows`) cycles. A `cfg_rows` of 0 counts as 1, and an interval of 0 counts as 1. One refresh becomes owed at the end of each interval. The first request appears exactly one interval after reset is released.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_row` stays unchanged in the next cycle.
- R4: A grant is a cycle with `req_valid` and `req_ready` both high. Each grant advances `req_row` by one. After a grant of row `cfg_rows`-1 (or any higher row), `req_row` becomes 0.
- R5: `wrap_pulse` is high for exactly the one cycle that follows the grant that returns `req_row` to 0.
- R6: The count of owed refreshes rises by one at each interval end and falls by one at each grant. When both happen in the same cycle, the count is unchanged. The count saturates at 8, and further interval ends are dropped. `req_valid` is high whenever the count is nonzero.
- R7: `urgent` is high whenever two or more refreshes are owed.
- R8: `wr_block` is high for the HOLD cycles (default 4) that start in the cycle after a grant. A new grant restarts that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rows | input | ROW_W+1 | Number of rows to sweep |
| cfg_period | input | PER_W | Retention window in clock cycles |
| req_valid | output | 1 | A refresh is owed |
| req_ready | input | 1 | Controller grants the offered refresh |
| req_row | output | ROW_W | Row to open for the offered refresh |
| urgent | output | 1 | Two or more refreshes owed |
| wrap_pulse | output | 1 | One-cycle flag at the end of each full sweep |
| wr_block | output | 1 | User writes must be held off |

## Verification
The bench checks the exact cycle of the first request after reset. A timer that counted one cycle too many or too few would raise `req_valid` a cycle early or late. It uses a window that does not divide evenly by the row count, which catches a rounded-up interval. It starves the grant input until the owed count pins at 8, then counts the grants needed to drain it. A design that kept counting past the limit, or that lost a refresh when a tick and a grant met, would drain in the wrong number of grants. Sweeps run through the last row, which exposes an off-by-one wrap or a wrap pulse on the wrong cycle. A single-cycle interval exercises the clamp path.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Owed-refresh count update: add on interval end, take on grant,
  // saturate at lim when adding without taking.
  function automatic int unsigned pend_next(int unsigned cur, logic add,
                                            logic take, int unsigned lim);
    int unsigned n;
    n = cur;
    if (add && !take) begin
      n = (cur >= lim) ? lim : cur + 1;
    end else if (!add && take && cur != 0) begin
      n = cur - 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int ROW_W = 13,
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W:0]   cfg_rows,
  input  logic [PER_W-1:0] cfg_period,
  output logic             tick
);

  logic [PER_W-1:0] rows_ext;
  logic [PER_W-1:0] quot;
  logic [PER_W-1:0] interval;
  logic [PER_W-1:0] cnt_q;

  // Interval = floor(period / rows), both clamped to at least 1.
  always_comb begin
    rows_ext = (cfg_rows == '0) ? PER_W'(1) : PER_W'(cfg_rows);
    quot     = cfg_period / rows_ext;
    interval = (quot == '0) ? PER_W'(1) : quot;
  end

  // Up-counter from zero; ">=" keeps it safe if the interval shrinks.
  assign tick = (cnt_q >= interval - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  // With a steady interval above one, interval ends never fall on adjacent cycles.
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && interval != PER_W'(1)) |=> (!tick || !$stable(interval)));

endmodule

// File: rtl/refresh_pending_tracker.sv
module refresh_pending_tracker #(
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ready,
  output logic valid,
  output logic urgent,
  output logic grant
);
  import refresh_pkg::*;

  localparam int PEND_W = $clog2(PEND_MAX + 1);

  logic [PEND_W-1:0] pend_q;

  assign valid  = (pend_q != '0);
  assign grant  = valid && ready;
  assign urgent = (pend_q >= PEND_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= PEND_W'(pend_next(32'(pend_q), tick, grant, PEND_MAX));
    end
  end

  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(PEND_MAX));

  assert_urgent_missed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !grant && valid) |=> urgent);

endmodule

// File: rtl/refresh_row_sweeper.sv
module refresh_row_sweeper #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W:0]   cfg_rows,
  input  logic             grant,
  output logic [ROW_W-1:0] row,
  output logic             wrap_pulse
);

  logic [ROW_W:0]   rows_eff;
  logic [ROW_W-1:0] row_q;
  logic             wrap_q;
  logic             last;

  assign rows_eff = (cfg_rows == '0) ? (ROW_W+1)'(1) : cfg_rows;
  assign last     = ({1'b0, row_q} >= rows_eff - (ROW_W+1)'(1));
  assign row        = row_q;
  assign wrap_pulse = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= grant && last;
      if (grant) begin
        row_q <= last ? '0 : row_q + ROW_W'(1);
      end
    end
  end

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !last) |=> (row_q == $past(row_q) + ROW_W'(1)));

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (row_q == '0));

endmodule

// File: rtl/refresh_write_guard.sv
module refresh_write_guard #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic wr_block
);

  localparam int HOLD_W = $clog2(HOLD + 1);

  logic [HOLD_W-1:0] left_q;

  assign wr_block = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (grant) begin
      left_q <= HOLD_W'(HOLD);
    end else if (left_q != '0) begin
      left_q <= left_q - HOLD_W'(1);
    end
  end

  assert_block_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> wr_block);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int ROW_W    = 13,
  parameter int PER_W    = 24,
  parameter int PEND_MAX = 8,
  parameter int HOLD     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W:0]   cfg_rows,
  input  logic [PER_W-1:0] cfg_period,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [ROW_W-1:0] req_row,
  output logic             urgent,
  output logic             wrap_pulse,
  output logic             wr_block
);

  logic tick;
  logic grant;

  refresh_interval_timer #(.ROW_W(ROW_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_period(cfg_period),
    .tick(tick)
  );

  refresh_pending_tracker #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ready(req_ready),
    .valid(req_valid), .urgent(urgent), .grant(grant)
  );

  refresh_row_sweeper #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .grant(grant),
    .row(req_row), .wrap_pulse(wrap_pulse)
  );

  refresh_write_guard #(.HOLD(HOLD)) u_guard (
    .clk(clk), .rst_n(rst_n), .grant(grant), .wr_block(wr_block)
  );

  assert_row_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(req_row));

endmodule

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;

  localparam int ROW_W = 13;
  localparam int PER_W = 24;
  localparam int HOLD  = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [ROW_W:0]   rows;
  logic [PER_W-1:0] period;
  logic             ready;
  logic             req_valid, urgent, wrap_pulse, wr_block;
  logic [ROW_W-1:0] req_row;

  int checks = 0;
  int fails  = 0;
  int m_cnt, m_pend, m_row, m_hold;
  bit m_wrap;

  always #5 clk = ~clk;

  refresh_scheduler #(.ROW_W(ROW_W), .PER_W(PER_W), .PEND_MAX(8), .HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_rows(rows), .cfg_period(period),
    .req_valid(req_valid), .req_ready(ready), .req_row(req_row),
    .urgent(urgent), .wrap_pulse(wrap_pulse), .wr_block(wr_block)
  );

  function automatic int ival();
    int r, q;
    r = (rows == 0) ? 1 : int'(rows);
    q = int'(period) / r;
    return (q == 0) ? 1 : q;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 req_valid", int'(req_valid), int'(m_pend > 0));
    chk("R4 req_row", int'(req_row), m_row);
    chk("R7 urgent", int'(urgent), int'(m_pend >= 2));
    chk("R5 wrap_pulse", int'(wrap_pulse), int'(m_wrap));
    chk("R8 wr_block", int'(wr_block), int'(m_hold > 0));
  endtask

  // One clock: model advances at the edge, outputs compared at the falling edge.
  task automatic step();
    bit tk, gr;
    int re;
    @(posedge clk);
    re = (rows == 0) ? 1 : int'(rows);
    tk = (m_cnt >= ival() - 1);
    gr = (m_pend > 0) && ready;
    m_cnt = tk ? 0 : m_cnt + 1;
    if (tk && !gr) m_pend = (m_pend >= 8) ? 8 : m_pend + 1;
    else if (!tk && gr) m_pend = m_pend - 1;
    m_wrap = gr && (m_row >= re - 1);
    if (gr) m_row = m_wrap ? 0 : m_row + 1;
    m_hold = gr ? HOLD : ((m_hold > 0) ? m_hold - 1 : 0);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ready = 1'b0;
    repeat (2) @(negedge clk);
    m_cnt = 0; m_pend = 0; m_row = 0; m_hold = 0; m_wrap = 0;
    // R1: reset state
    chk("R1 reset req_valid", int'(req_valid), 0);
    chk("R1 reset req_row", int'(req_row), 0);
    chk("R1 reset urgent", int'(urgent), 0);
    chk("R1 reset wrap_pulse", int'(wrap_pulse), 0);
    chk("R1 reset wr_block", int'(wr_block), 0);
    rst_n = 1'b1;
  endtask

  task automatic first_request(int exp);
    int n;
    n = 0;
    while (!req_valid && n < 2000) begin
      step();
      n++;
    end
    chk("R2 first request delay", n, exp);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; ready = 1'b0;
    rows = 14'd8; period = 24'd40;

    // Phase 1: even interval 5, always ready; sweeps and wraps (R2, R4, R5, R8)
    do_reset();
    first_request(5);
    for (int i = 0; i < 120; i++) begin
      ready = 1'b1;
      step();
    end

    // Phase 2: 20/6 rounds down to 3; sparse grants build a backlog (R2, R3, R6, R7)
    rows = 14'd6; period = 24'd20;
    do_reset();
    first_request(3);
    for (int i = 0; i < 150; i++) begin
      ready = (i % 5 == 0);
      step();
    end

    // Phase 3: starve until saturated, then drain (R6, R7)
    rows = 14'd4; period = 24'd400;
    do_reset();
    for (int i = 0; i < 950; i++) begin
      ready = 1'b0;
      step();
    end
    chk("R7 urgent while starved", int'(urgent), 1);
    ready = 1'b1;
    n = 0;
    while (req_valid && n < 50) begin
      step();
      n++;
    end
    chk("R6 saturated backlog drains in 8 grants", n, 8);

    // Phase 4: period below row count clamps interval to 1; rows 0 treated as 1 (R2, R4, R5)
    rows = 14'd4; period = 24'd2;
    do_reset();
    first_request(1);
    for (int i = 0; i < 40; i++) begin
      ready = (i % 2 == 0);
      step();
    end
    rows = 14'd0; period = 24'd3;
    do_reset();
    first_request(3);
    for (int i = 0; i < 30; i++) begin
      ready = 1'b1;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule